// File: doc/BRIEF.md
# Ethernet Receive Header Field Extractor

This block sits behind a receive deserializer that has already found the frame delimiter and delivers whole octets. It counts the octets of each frame and pulls out the three leading header fields: destination hardware address, source hardware address and the two-octet EtherType. The captured values sit in output registers for display or downstream classification, and a flag tells whether the destination was the all-ones broadcast address.

Header octets are collected in a shadow shift register while the frame is arriving. The outputs change only when the final header octet is accepted, so a frame cut short before its header is complete never leaves a half-updated set of fields. A one-cycle completion pulse marks each commit. Payload octets after the header are not counted further and never touch the outputs.

Top module: `hfx_eth_hdr_extract`

## Requirements
- R1: While reset is low and after its release, `dst_addr`, `src_addr`, `eth_type`, `is_bcast` and `hdr_done` are all zero until the first complete header is committed.
- R2: Counting from the octet marked by `in_sof` as octet 0, octets 0 to 5 form `dst_addr`, octets 6 to 11 form `src_addr` and octets 12 to 13 form `eth_type`; within each field the first octet received is the most significant.
- R3: `is_bcast` becomes 1 exactly when the committed destination is 48'hFFFF_FFFF_FFFF and 0 for any other destination; it changes in the same cycle as the other fields.
- R4: The outputs keep the last complete header; a frame whose `in_eof` arrives before octet 13 is accepted changes no output and produces no `hdr_done`.
- R5: `hdr_done` is high for exactly one cycle, the cycle after octet 13 is accepted, and occurs once per frame; the new field values are visible in that same cycle.
- R6: Octets after octet 13 of a frame change no output and raise no further `hdr_done`.
- R7: Cycles with `in_valid` low are ignored whatever `in_byte` holds, so gaps inside a header are allowed; octets with `in_valid` high outside a frame (before any `in_sof`, or after `in_eof`) are ignored.
- R8: `in_sof` with `in_valid` during an unfinished header restarts counting, with that octet taken as octet 0 of a new frame.
- R9: When `in_eof` coincides with octet 13, that octet is still accepted and the header is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Received octet |
| in_valid | input | 1 | `in_byte` holds an octet this cycle |
| in_sof | input | 1 | With `in_valid`: this octet is octet 0 of a frame |
| in_eof | input | 1 | Frame ends this cycle (an octet valid in the same cycle is its last) |
| dst_addr | output | 48 | Destination address of the last complete header |
| src_addr | output | 48 | Source address of the last complete header |
| eth_type | output | 16 | EtherType of the last complete header |
| is_bcast | output | 1 | Last committed destination was all ones |
| hdr_done | output | 1 | One-cycle pulse when a header is committed |

## Verification
The bench aims at the frame that stops after nine octets, where a design writing fields straight to the outputs would leave a mix of old and new addresses. It restarts a frame mid-header, which a counter that ignores a fresh start marker would mis-slice into shifted fields, and ends a frame exactly on octet 13, which a design letting end-of-frame win over the octet would drop. It also sends a destination that differs from broadcast only in its last bit, trips a comparator that looks at too few octets, and inserts invalid cycles carrying junk inside a header, which would corrupt fields if sampled.

// File: rtl/hfx_pkg.sv
package hfx_pkg;
    // Progress of the per-frame octet counter
    typedef enum logic [1:0] {
        CNT_IDLE      = 2'd0,  // outside a frame, octets ignored
        CNT_COLLECT   = 2'd1,  // header octets being gathered
        CNT_SATURATED = 2'd2   // header finished, payload ignored
    } cnt_state_e;

    localparam int unsigned OCTET_W = 8;
endpackage

// File: rtl/hfx_byte_counter.sv
module hfx_byte_counter
    import hfx_pkg::*;
#(
    parameter int unsigned HDR_BYTES = 14,
    localparam int unsigned CNT_W = $clog2(HDR_BYTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eof,
    output logic accept,
    output logic last_byte
);
    typedef struct packed {
        cnt_state_e       state;
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        accept    = 1'b0;
        last_byte = 1'b0;
        if (in_valid && in_sof) begin
            // a start marker always opens a new frame at octet 0
            accept      = 1'b1;
            nxt_d.state = CNT_COLLECT;
            nxt_d.cnt   = CNT_W'(1);
        end else if (in_valid && cur_q.state == CNT_COLLECT) begin
            accept    = 1'b1;
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
            if (cur_q.cnt == CNT_W'(HDR_BYTES - 1)) begin
                last_byte   = 1'b1;
                nxt_d.state = CNT_SATURATED;
            end
        end
        // end of frame closes it after the octet of this cycle is taken
        if (in_eof) begin
            nxt_d.state = CNT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: CNT_IDLE, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/hfx_hdr_shift.sv
module hfx_hdr_shift
    import hfx_pkg::*;
#(
    parameter int unsigned HDR_BYTES = 14,
    localparam int unsigned SHADOW_W = (HDR_BYTES - 1) * OCTET_W,
    localparam int unsigned HDR_W    = HDR_BYTES * OCTET_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [OCTET_W-1:0] in_byte,
    output logic [HDR_W-1:0]   hdr_next
);
    logic [SHADOW_W-1:0] shadow_q, shadow_d;

    // the header as it stands if the current octet is the last one
    assign hdr_next = {shadow_q, in_byte};

    always_comb begin
        shadow_d = shadow_q;
        if (accept) begin
            shadow_d = hdr_next[SHADOW_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= shadow_d;
        end
    end
endmodule

// File: rtl/hfx_bcast_cmp.sv
module hfx_bcast_cmp
    import hfx_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic [ADDR_BYTES*OCTET_W-1:0] addr,
    output logic                          all_ones
);
    logic [ADDR_BYTES-1:0] octet_hit;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_octet
        assign octet_hit[g] = (addr[g*OCTET_W +: OCTET_W] == {OCTET_W{1'b1}});
    end

    assign all_ones = &octet_hit;
endmodule

// File: rtl/hfx_eth_hdr_extract.sv
module hfx_eth_hdr_extract
    import hfx_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned TYPE_BYTES = 2,
    localparam int unsigned ADDR_W    = ADDR_BYTES * OCTET_W,
    localparam int unsigned TYPE_W    = TYPE_BYTES * OCTET_W,
    localparam int unsigned HDR_BYTES = 2 * ADDR_BYTES + TYPE_BYTES,
    localparam int unsigned HDR_W     = HDR_BYTES * OCTET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_byte,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [ADDR_W-1:0] src_addr,
    output logic [TYPE_W-1:0] eth_type,
    output logic              is_bcast,
    output logic              hdr_done
);
    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [TYPE_W-1:0] typ;
        logic              bcast;
        logic              done;
    } fields_t;

    logic             accept;
    logic             last_byte;
    logic [HDR_W-1:0] hdr_next;
    logic             dst_ones;
    fields_t          out_q, out_d;

    hfx_byte_counter #(.HDR_BYTES(HDR_BYTES)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .accept    (accept),
        .last_byte (last_byte)
    );

    hfx_hdr_shift #(.HDR_BYTES(HDR_BYTES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_byte  (in_byte),
        .hdr_next (hdr_next)
    );

    hfx_bcast_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_bcast (
        .addr     (hdr_next[HDR_W-1 -: ADDR_W]),
        .all_ones (dst_ones)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = 1'b0;
        if (last_byte) begin
            out_d.dst   = hdr_next[HDR_W-1 -: ADDR_W];
            out_d.src   = hdr_next[TYPE_W+ADDR_W-1 -: ADDR_W];
            out_d.typ   = hdr_next[TYPE_W-1:0];
            out_d.bcast = dst_ones;
            out_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dst_addr = out_q.dst;
    assign src_addr = out_q.src;
    assign eth_type = out_q.typ;
    assign is_bcast = out_q.bcast;
    assign hdr_done = out_q.done;
endmodule

// File: rtl/hfx_checks.sv
module hfx_checks #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned TYPE_BYTES = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [7:0]              in_byte,
    input logic                    in_valid,
    input logic [ADDR_BYTES*8-1:0] dst_addr,
    input logic [ADDR_BYTES*8-1:0] src_addr,
    input logic [TYPE_BYTES*8-1:0] eth_type,
    input logic                    is_bcast,
    input logic                    hdr_done
);
    // R5: commit pulse never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> !hdr_done);

    // R4: without a commit every output holds
    a_r4_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_done |-> ($stable(dst_addr) && $stable(src_addr)
                       && $stable(eth_type) && $stable(is_bcast)));

    // R3: flag agrees with the committed destination
    a_r3_bcast_match: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> (is_bcast == (&dst_addr)));

    // R2: lowest type octet is the octet accepted one cycle earlier
    a_r2_type_tail: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> ($past(in_valid) && eth_type[7:0] == $past(in_byte)));

    // R7: an invalid cycle cannot complete a header
    a_r7_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !hdr_done);
endmodule

bind hfx_eth_hdr_extract hfx_checks #(
    .ADDR_BYTES (ADDR_BYTES),
    .TYPE_BYTES (TYPE_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_byte  (in_byte),
    .in_valid (in_valid),
    .dst_addr (dst_addr),
    .src_addr (src_addr),
    .eth_type (eth_type),
    .is_bcast (is_bcast),
    .hdr_done (hdr_done)
);

// File: tb/sim_hfx_eth_hdr_extract.sv
`timescale 1ns/1ps
module sim_hfx_eth_hdr_extract;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [47:0] dst_addr, src_addr;
    logic [15:0] eth_type;
    logic        is_bcast, hdr_done;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done_at_last;
    bit finished = 0;

    always #2 clk = ~clk;

    hfx_eth_hdr_extract u0 (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .dst_addr(dst_addr),
        .src_addr(src_addr), .eth_type(eth_type), .is_bcast(is_bcast),
        .hdr_done(hdr_done)
    );

    always @(negedge clk) if (rst_n && hdr_done) pulses++;

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // inputs change at a falling edge; results are read at the next falling edge
    task automatic put(input logic [7:0] b, input logic v, input logic s, input logic e);
        in_byte = b; in_valid = v; in_sof = s; in_eof = e;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [47:0] d, input logic [47:0] s,
                              input logic [15:0] t, input int payload,
                              input int gap, input bit eof_last);
        logic [111:0] hb;
        hb = {d, s, t};
        for (int i = 0; i < 14; i++) begin
            put(hb[111-8*i -: 8], 1'b1, i == 0, eof_last && i == 13);
            if (i == 13) done_at_last = hdr_done;
            else for (int g = 0; g < gap; g++) put(8'hA5, 1'b0, 1'b0, 1'b0);
        end
        for (int k = 0; k < payload; k++)
            put(8'(k * 37), 1'b1, 1'b0, k == payload - 1);
        if (!eof_last && payload == 0) put(8'h00, 1'b0, 1'b0, 1'b1);
        put(8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 dst", dst_addr, 48'h0);
        chk("R1 src", src_addr, 48'h0);
        chk("R1 type", {32'h0, eth_type}, 48'h0);
        chk("R1 bcast", {47'h0, is_bcast}, 48'h0);
        chk("R1 done", {47'h0, hdr_done}, 48'h0);
    endtask

    task automatic t_unicast();
        int p0 = pulses;
        send_frame(48'h0211_2233_4455, 48'h2244_66AB_CDEF, 16'h0800, 6, 0, 0);
        chk("R5 done at octet 13", {47'h0, done_at_last}, 48'h1);
        chk("R2 dst", dst_addr, 48'h0211_2233_4455);
        chk("R2 src", src_addr, 48'h2244_66AB_CDEF);
        chk("R2 type", {32'h0, eth_type}, 48'h0800);
        chk("R3 unicast", {47'h0, is_bcast}, 48'h0);
        chk("R6 one pulse despite payload", 48'(pulses - p0), 48'h1);
    endtask

    task automatic t_bcast_gaps();
        int p0 = pulses;
        send_frame(48'hFFFF_FFFF_FFFF, 48'h0A0B_0C0D_0E0F, 16'h0806, 2, 2, 0);
        chk("R7 gaps dst", dst_addr, 48'hFFFF_FFFF_FFFF);
        chk("R7 gaps src", src_addr, 48'h0A0B_0C0D_0E0F);
        chk("R7 gaps type", {32'h0, eth_type}, 48'h0806);
        chk("R3 broadcast", {47'h0, is_bcast}, 48'h1);
        chk("R5 pulse count", 48'(pulses - p0), 48'h1);
    endtask

    task automatic t_truncated();
        int p0 = pulses;
        for (int i = 0; i < 9; i++) put(8'(8'h30 + i), 1'b1, i == 0, i == 8);
        put(8'h00, 1'b0, 1'b0, 1'b0);
        chk("R4 short frame dst kept", dst_addr, 48'hFFFF_FFFF_FFFF);
        chk("R4 short frame src kept", src_addr, 48'h0A0B_0C0D_0E0F);
        chk("R4 no pulse", 48'(pulses - p0), 48'h0);
        // stray valid octets with no start marker
        for (int i = 0; i < 20; i++) put(8'(8'hC0 + i), 1'b1, 1'b0, 1'b0);
        put(8'h00, 1'b0, 1'b0, 1'b0);
        chk("R7 stray octets no pulse", 48'(pulses - p0), 48'h0);
        chk("R7 stray octets type kept", {32'h0, eth_type}, 48'h0806);
    endtask

    task automatic t_restart();
        int p0 = pulses;
        for (int i = 0; i < 5; i++) put(8'(8'h11 * (i + 1)), 1'b1, i == 0, 1'b0);
        send_frame(48'h1020_3040_5060, 48'h7080_90A0_B0C0, 16'h88CC, 0, 0, 0);
        chk("R8 restart dst", dst_addr, 48'h1020_3040_5060);
        chk("R8 restart src", src_addr, 48'h7080_90A0_B0C0);
        chk("R8 restart type", {32'h0, eth_type}, 48'h88CC);
        chk("R8 single pulse", 48'(pulses - p0), 48'h1);
    endtask

    task automatic t_eof_last();
        int p0 = pulses;
        send_frame(48'hFFFF_FFFF_FFFE, 48'h0000_0000_0001, 16'h86DD, 0, 0, 1);
        chk("R9 done on eof octet", {47'h0, done_at_last}, 48'h1);
        chk("R9 dst", dst_addr, 48'hFFFF_FFFF_FFFE);
        chk("R9 type", {32'h0, eth_type}, 48'h86DD);
        chk("R3 near broadcast", {47'h0, is_bcast}, 48'h0);
        for (int i = 0; i < 6; i++) put(8'hFF, 1'b1, 1'b0, 1'b0);
        chk("R6 after eof no pulse", 48'(pulses - p0), 48'h1);
        chk("R6 after eof dst kept", dst_addr, 48'hFFFF_FFFF_FFFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast_gaps();
        t_truncated();
        t_restart();
        t_eof_last();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule